// File: doc/BRIEF.md
# Lag-Search Complex Correlator

This block estimates the time offset between a stored complex reference of `REF_LEN` samples and a captured complex window of `2*REF_LEN` samples. Software or an upstream engine writes the reference through an addressed load port and streams the capture window in through a valid-qualified sample input. A start strobe then launches a search over `2*REF_LEN+1` lag positions. For each lag a pipelined multiply-accumulate forms the complex dot product of the capture against the conjugated reference. The accumulated value is squared per component and summed, and the lag with the largest squared magnitude is kept.

The search is sequenced by a six-state machine:
- `ST_IDLE`: accepts samples and start.
- `ST_MAC`: issues one product per cycle for `REF_LEN` cycles.
- `ST_DRAIN`: lets the last product land in the accumulator.
- `ST_SQUARE`: registers I²+Q².
- `ST_PICK`: compares against the best so far and advances the lag.
- `ST_DONE`: raises the completion pulse.

The state transitions are:
- `ST_IDLE`→`ST_MAC` on start.
- `ST_MAC`→`ST_DRAIN` after the last reference index.
- `ST_DRAIN`→`ST_SQUARE`→`ST_PICK` unconditionally.
- `ST_PICK`→`ST_MAC` while lags remain.
- `ST_PICK`→`ST_DONE` after lag `2*REF_LEN`.
- `ST_DONE`→`ST_IDLE`.

The reported lag is a raw index, not a signed offset. A capture that holds the reference starting at its first sample peaks at index `REF_LEN`. No square root and no normalisation are applied.

Top module: `lag_correlator`

## Requirements
- R1: A reference sample is written at `ref_addr` when `ref_we` is high. Capture samples are stored in arrival order into positions 0 to 2N-1, one per cycle with `cap_valid` high while idle. The first sample after reset, or after any accepted start, goes to position 0.
- R2: The value for lag index k (0..2N) is the sum over n=0..N-1 of cap[n+k-N]·conj(ref[n]). Its real part is ci·ri+cq·rq and its imaginary part is cq·ri−ci·rq. A capture position below 0 counts as zero, and zero delay lands at index N.
- R3: `peak_mag` is I²+Q² of the winning lag without normalisation. A ±1 real reference matched against itself gives N² at index N.
- R4: When several lags share the maximum, the lowest index is reported.
- R5: `done` is high for exactly one cycle. It rises (2N+1)·(N+3) clock edges after the edge that samples `start`.
- R6: `busy` is high from the edge that accepts `start` until `done` rises. `start` and `cap_valid` have no effect while busy.
- R7: After reset, `busy`, `done`, `peak_lag` and `peak_mag` are zero. The peak outputs hold their value while idle.
- R8: The final lag index 2N is evaluated and can win.
- R9: The accumulator is 2W+1+ceil(log2 N) bits wide, so full-scale inputs at every position produce the exact sum without wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_we | input | 1 | Reference write enable |
| ref_addr | input | clog2(REF_LEN) | Reference write index |
| ref_i | input | SAMPLE_W | Reference in-phase value, signed |
| ref_q | input | SAMPLE_W | Reference quadrature value, signed |
| cap_valid | input | 1 | Capture sample valid |
| cap_i | input | SAMPLE_W | Capture in-phase value, signed |
| cap_q | input | SAMPLE_W | Capture quadrature value, signed |
| start | input | 1 | Launch a lag search (idle only) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| peak_lag | output | clog2(2*REF_LEN+1) | Index of the winning lag |
| peak_mag | output | 2*(2*SAMPLE_W+1+clog2(REF_LEN)) | Squared magnitude of the winning lag |

## Verification
The checker watches the control contract on every cycle:
- `done` is a single-cycle pulse, preceded by a busy cycle and never coincident with busy.
- An idle start always makes the block busy.
- The reported index never leaves the lag range.
- The peak outputs stay frozen while idle.

The numerical content can only be shown by the bench scenarios. These cover the lag arithmetic with zero fill at the early edge, the centre convention, tie-breaking toward the earliest lag, the last lag winning, full-scale accumulation, the exact latency, and the immunity of the stored capture to traffic arriving mid-search.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_DRAIN,
        ST_SQUARE,
        ST_PICK,
        ST_DONE
    } corr_state_t;

endpackage

// File: rtl/lagcorr_buffers.sv
module lagcorr_buffers #(
    parameter  int REF_LEN  = 8,
    parameter  int SAMPLE_W = 8,
    localparam int CAP_LEN  = 2 * REF_LEN,
    localparam int RA_W     = $clog2(REF_LEN),
    localparam int CA_W     = $clog2(CAP_LEN),
    localparam int LAG_W    = $clog2(2 * REF_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ref_we,
    input  logic [RA_W-1:0]            ref_addr,
    input  logic signed [SAMPLE_W-1:0] ref_wi,
    input  logic signed [SAMPLE_W-1:0] ref_wq,
    input  logic                       cap_we,
    input  logic signed [SAMPLE_W-1:0] cap_wi,
    input  logic signed [SAMPLE_W-1:0] cap_wq,
    input  logic                       ptr_clear,
    input  logic [RA_W-1:0]            rd_n,
    input  logic [LAG_W-1:0]           rd_lag,
    output logic signed [SAMPLE_W-1:0] r_i,
    output logic signed [SAMPLE_W-1:0] r_q,
    output logic signed [SAMPLE_W-1:0] c_i,
    output logic signed [SAMPLE_W-1:0] c_q
);

    logic signed [SAMPLE_W-1:0] ref_i_mem [REF_LEN];
    logic signed [SAMPLE_W-1:0] ref_q_mem [REF_LEN];
    logic signed [SAMPLE_W-1:0] cap_i_mem [CAP_LEN];
    logic signed [SAMPLE_W-1:0] cap_q_mem [CAP_LEN];
    logic [CA_W-1:0]            wptr;
    logic signed [31:0]         pos;

    // reference storage: one slot per generated entry
    for (genvar g = 0; g < REF_LEN; g++) begin : g_ref
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_i_mem[g] <= '0;
                ref_q_mem[g] <= '0;
            end else if (ref_we && (int'(ref_addr) == g)) begin
                ref_i_mem[g] <= ref_wi;
                ref_q_mem[g] <= ref_wq;
            end
        end
    end

    // capture storage: sequential fill with wrapping pointer
    for (genvar g = 0; g < CAP_LEN; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_i_mem[g] <= '0;
                cap_q_mem[g] <= '0;
            end else if (cap_we && (int'(wptr) == g)) begin
                cap_i_mem[g] <= cap_wi;
                cap_q_mem[g] <= cap_wq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || ptr_clear) begin
            wptr <= '0;
        end else if (cap_we) begin
            wptr <= (wptr == CA_W'(CAP_LEN - 1)) ? '0 : wptr + 1'b1;
        end
    end

    // read side: capture position n + k - N, zero outside the window
    always_comb begin
        pos = int'(rd_n) + int'(rd_lag) - REF_LEN;
        r_i = ref_i_mem[rd_n];
        r_q = ref_q_mem[rd_n];
        c_i = '0;
        c_q = '0;
        if (pos >= 0 && pos < CAP_LEN) begin
            c_i = cap_i_mem[pos[CA_W-1:0]];
            c_q = cap_q_mem[pos[CA_W-1:0]];
        end
    end

endmodule

// File: rtl/lagcorr_mac.sv
module lagcorr_mac #(
    parameter  int REF_LEN  = 8,
    parameter  int SAMPLE_W = 8,
    localparam int PROD_W   = 2 * SAMPLE_W + 1,
    localparam int ACC_W    = PROD_W + $clog2(REF_LEN),
    localparam int MAG_W    = 2 * ACC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue,
    input  logic                       clear,
    input  logic                       sq_en,
    input  logic signed [SAMPLE_W-1:0] r_i,
    input  logic signed [SAMPLE_W-1:0] r_q,
    input  logic signed [SAMPLE_W-1:0] c_i,
    input  logic signed [SAMPLE_W-1:0] c_q,
    output logic [MAG_W-1:0]           mag
);

    logic signed [2*SAMPLE_W-1:0] m_ii, m_qq, m_qi, m_iq;
    logic signed [PROD_W-1:0]     p_re_nx, p_im_nx, p_re, p_im;
    logic                         p_v;
    logic signed [ACC_W-1:0]      acc_re, acc_im;
    logic signed [MAG_W-1:0]      sq_re, sq_im;

    // capture times conjugated reference
    always_comb begin
        m_ii    = c_i * r_i;
        m_qq    = c_q * r_q;
        m_qi    = c_q * r_i;
        m_iq    = c_i * r_q;
        p_re_nx = PROD_W'(m_ii) + PROD_W'(m_qq);
        p_im_nx = PROD_W'(m_qi) - PROD_W'(m_iq);
        sq_re   = acc_re * acc_re;
        sq_im   = acc_im * acc_im;
    end

    // stage 1: product register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_re <= '0;
            p_im <= '0;
            p_v  <= 1'b0;
        end else begin
            p_v <= issue;
            if (issue) begin
                p_re <= p_re_nx;
                p_im <= p_im_nx;
            end
        end
    end

    // stage 2: accumulate
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (p_v) begin
            acc_re <= acc_re + ACC_W'(p_re);
            acc_im <= acc_im + ACC_W'(p_im);
        end
    end

    // one multiply stage for the squared magnitude
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag <= '0;
        end else if (sq_en) begin
            mag <= $unsigned(sq_re) + $unsigned(sq_im);
        end
    end

endmodule

// File: rtl/lagcorr_peak.sv
module lagcorr_peak #(
    parameter int MAG_W = 40,
    parameter int LAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             update,
    input  logic [LAG_W-1:0] lag_in,
    input  logic [MAG_W-1:0] mag_in,
    output logic [LAG_W-1:0] best_lag,
    output logic [MAG_W-1:0] best_mag
);

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            best_lag <= '0;
            best_mag <= '0;
        end else if (update && (mag_in > best_mag)) begin
            best_lag <= lag_in;
            best_mag <= mag_in;
        end
    end

endmodule

// File: rtl/lag_correlator.sv
module lag_correlator
    import lagcorr_pkg::*;
#(
    parameter  int REF_LEN  = 8,
    parameter  int SAMPLE_W = 8,
    localparam int NUM_LAGS = 2 * REF_LEN + 1,
    localparam int RA_W     = $clog2(REF_LEN),
    localparam int LAG_W    = $clog2(NUM_LAGS),
    localparam int ACC_W    = 2 * SAMPLE_W + 1 + $clog2(REF_LEN),
    localparam int MAG_W    = 2 * ACC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_we,
    input  logic [RA_W-1:0]     ref_addr,
    input  logic [SAMPLE_W-1:0] ref_i,
    input  logic [SAMPLE_W-1:0] ref_q,
    input  logic                cap_valid,
    input  logic [SAMPLE_W-1:0] cap_i,
    input  logic [SAMPLE_W-1:0] cap_q,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic [LAG_W-1:0]    peak_lag,
    output logic [MAG_W-1:0]    peak_mag
);

    localparam logic [LAG_W-1:0] LAST_LAG = LAG_W'(NUM_LAGS - 1);
    localparam logic [RA_W-1:0]  LAST_N   = RA_W'(REF_LEN - 1);

    corr_state_t                state, state_nx;
    logic [RA_W-1:0]            n_cnt;
    logic [LAG_W-1:0]           lag_cnt;
    logic                       accept;
    logic signed [SAMPLE_W-1:0] rd_ri, rd_rq, rd_ci, rd_cq;
    logic [MAG_W-1:0]           lag_mag;

    assign accept = (state == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_MAC;
            ST_MAC:    if (n_cnt == LAST_N) state_nx = ST_DRAIN;
            ST_DRAIN:  state_nx = ST_SQUARE;
            ST_SQUARE: state_nx = ST_PICK;
            ST_PICK:   state_nx = (lag_cnt == LAST_LAG) ? ST_DONE : ST_MAC;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // index counters driven from the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cnt   <= '0;
            lag_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    n_cnt   <= '0;
                    lag_cnt <= '0;
                end
                ST_MAC:  n_cnt <= (n_cnt == LAST_N) ? '0 : n_cnt + 1'b1;
                ST_PICK: begin
                    n_cnt <= '0;
                    if (lag_cnt != LAST_LAG) lag_cnt <= lag_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != ST_IDLE) && (state != ST_DONE);
    assign done = (state == ST_DONE);

    lagcorr_buffers #(.REF_LEN(REF_LEN), .SAMPLE_W(SAMPLE_W)) u_buffers (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_we    (ref_we && (state == ST_IDLE)),
        .ref_addr  (ref_addr),
        .ref_wi    ($signed(ref_i)),
        .ref_wq    ($signed(ref_q)),
        .cap_we    (cap_valid && (state == ST_IDLE) && !start),
        .cap_wi    ($signed(cap_i)),
        .cap_wq    ($signed(cap_q)),
        .ptr_clear (accept),
        .rd_n      (n_cnt),
        .rd_lag    (lag_cnt),
        .r_i       (rd_ri),
        .r_q       (rd_rq),
        .c_i       (rd_ci),
        .c_q       (rd_cq)
    );

    lagcorr_mac #(.REF_LEN(REF_LEN), .SAMPLE_W(SAMPLE_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (state == ST_MAC),
        .clear (accept || (state == ST_PICK)),
        .sq_en (state == ST_SQUARE),
        .r_i   (rd_ri),
        .r_q   (rd_rq),
        .c_i   (rd_ci),
        .c_q   (rd_cq),
        .mag   (lag_mag)
    );

    lagcorr_peak #(.MAG_W(MAG_W), .LAG_W(LAG_W)) u_peak (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (accept),
        .update   (state == ST_PICK),
        .lag_in   (lag_cnt),
        .mag_in   (lag_mag),
        .best_lag (peak_lag),
        .best_mag (peak_mag)
    );

endmodule

// File: rtl/lag_correlator_checks.sv
module lag_correlator_checks #(
    parameter  int REF_LEN  = 8,
    parameter  int SAMPLE_W = 8,
    localparam int NUM_LAGS = 2 * REF_LEN + 1,
    localparam int LAG_W    = $clog2(NUM_LAGS),
    localparam int MAG_W    = 2 * (2 * SAMPLE_W + 1 + $clog2(REF_LEN))
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [LAG_W-1:0] peak_lag,
    input logic [MAG_W-1:0] peak_mag
);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held longer than one cycle");

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)) else $error("done without a preceding search");

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done and busy together");

    assert_start_launches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy) else $error("idle start not accepted");

    assert_lag_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        peak_lag <= LAG_W'(NUM_LAGS - 1)) else $error("lag index out of range");

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(peak_lag) && $stable(peak_mag)))
        else $error("peak outputs moved while idle");

endmodule

bind lag_correlator lag_correlator_checks #(.REF_LEN(REF_LEN), .SAMPLE_W(SAMPLE_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .peak_lag (peak_lag),
    .peak_mag (peak_mag)
);

// File: tb/lag_correlator_bench.sv
module lag_correlator_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int W          = 8;
    localparam int LAGS       = 2 * N + 1;
    localparam int LAT        = LAGS * (N + 3);
    localparam int RA_W       = $clog2(N);
    localparam int LAG_W      = $clog2(LAGS);
    localparam int MAG_W      = 2 * (2 * W + 1 + $clog2(N));

    logic clk = 1'b0;
    logic rst_n;
    logic ref_we, cap_valid, start;
    logic [RA_W-1:0] ref_addr;
    logic [W-1:0] ref_i, ref_q, cap_i, cap_q;
    logic busy, done;
    logic [LAG_W-1:0] peak_lag;
    logic [MAG_W-1:0] peak_mag;

    int checks = 0;
    int errors = 0;

    longint m_ri [N];
    longint m_rq [N];
    longint m_ci [2*N];
    longint m_cq [2*N];
    longint got_lag, got_mag;

    always #(CLK_PERIOD/2) clk = ~clk;

    lag_correlator #(.REF_LEN(N), .SAMPLE_W(W)) u_lag_correlator (
        .clk(clk), .rst_n(rst_n), .ref_we(ref_we), .ref_addr(ref_addr),
        .ref_i(ref_i), .ref_q(ref_q), .cap_valid(cap_valid), .cap_i(cap_i),
        .cap_q(cap_q), .start(start), .busy(busy), .done(done),
        .peak_lag(peak_lag), .peak_mag(peak_mag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint pm1(input int n);
        return (((n * 5 + 3) % 7) < 3) ? 64'sd1 : -64'sd1;
    endfunction

    // independent model of the lag search from the requirements
    task automatic model(output longint lag, output longint mag);
        lag = 0;
        mag = 0;
        for (int k = 0; k < LAGS; k++) begin
            longint sre = 0, sim = 0, m;
            for (int n = 0; n < N; n++) begin
                int j = n + k - N;
                if (j >= 0 && j < 2*N) begin
                    sre += m_ci[j] * m_ri[n] + m_cq[j] * m_rq[n];
                    sim += m_cq[j] * m_ri[n] - m_ci[j] * m_rq[n];
                end
            end
            m = sre * sre + sim * sim;
            if (m > mag) begin
                mag = m;
                lag = k;
            end
        end
    endtask

    task automatic load_all();
        for (int a = 0; a < N; a++) begin
            ref_we = 1'b1; ref_addr = RA_W'(a);
            ref_i = W'(m_ri[a]); ref_q = W'(m_rq[a]);
            @(negedge clk);
        end
        ref_we = 1'b0;
        for (int j = 0; j < 2*N; j++) begin
            cap_valid = 1'b1;
            cap_i = W'(m_ci[j]); cap_q = W'(m_cq[j]);
            @(negedge clk);
        end
        cap_valid = 1'b0;
    endtask

    task automatic clear_model();
        for (int a = 0; a < N; a++) begin m_ri[a] = 0; m_rq[a] = 0; end
        for (int j = 0; j < 2*N; j++) begin m_ci[j] = 0; m_cq[j] = 0; end
    endtask

    // run one search; optionally disturb inputs while busy
    task automatic run(input bit disturb);
        int edges = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R6 busy after start", longint'(busy), 1);
        while (done !== 1'b1 && edges < 4 * LAT) begin
            if (disturb && edges == 5) begin
                start = 1'b1; cap_valid = 1'b1; cap_i = 8'h55; cap_q = 8'hA3;
            end
            if (disturb && edges == 9) begin
                start = 1'b0; cap_valid = 1'b0;
            end
            @(negedge clk);
            edges++;
        end
        check(edges == LAT, "R5 latency edges", edges, LAT);
        check(busy === 1'b0, "R6 busy low at done", longint'(busy), 0);
        got_lag = longint'(peak_lag);
        got_mag = longint'(peak_mag);
        @(negedge clk);
        check(done === 1'b0, "R5 done single cycle", longint'(done), 0);
    endtask

    task automatic expect_model(input string req);
        longint el, em;
        model(el, em);
        check(got_lag == el, req, got_lag, el);
        check(got_mag == em, req, got_mag, em);
    endtask

    task automatic t_reset();
        check(busy === 1'b0 && done === 1'b0, "R7 reset busy/done", longint'({busy, done}), 0);
        check(peak_lag === '0, "R7 reset peak_lag", longint'(peak_lag), 0);
        check(peak_mag === '0, "R7 reset peak_mag", longint'(peak_mag), 0);
    endtask

    task automatic t_autocorr();
        clear_model();
        for (int n = 0; n < N; n++) begin m_ri[n] = pm1(n); m_ci[n] = pm1(n); end
        load_all();
        run(1'b0);
        check(got_lag == N, "R3 autocorr centre lag", got_lag, N);
        check(got_mag == N * N, "R3 autocorr magnitude", got_mag, N * N);
        repeat (5) @(negedge clk);
        check(longint'(peak_lag) == got_lag && longint'(peak_mag) == got_mag,
              "R7 hold while idle", longint'(peak_mag), got_mag);
        run(1'b1);
        check(got_lag == N && got_mag == N * N, "R6 start/capture ignored while busy", got_mag, N * N);
        run(1'b0);
        check(got_lag == N && got_mag == N * N, "R6 capture kept after busy traffic", got_mag, N * N);
    endtask

    task automatic t_delay_complex();
        clear_model();
        for (int n = 0; n < N; n++) begin
            m_ri[n] = ((n * 3) % 7) - 3;
            m_rq[n] = ((n * 5) % 9) - 4;
            m_ci[n + 3] = m_ri[n];
            m_cq[n + 3] = m_rq[n];
        end
        load_all();
        run(1'b0);
        expect_model("R1 R2 delayed complex capture");
    endtask

    task automatic t_last_lag();
        clear_model();
        for (int n = 0; n < N; n++) begin m_ri[n] = pm1(n); m_ci[n + N] = pm1(n); end
        load_all();
        run(1'b0);
        check(got_lag == 2 * N, "R8 last lag wins", got_lag, 2 * N);
        check(got_mag == N * N, "R8 last lag magnitude", got_mag, N * N);
    endtask

    task automatic t_early_edge();
        clear_model();
        for (int n = 0; n < N; n++) m_ri[n] = pm1(n);
        for (int j = 0; j < N - 3; j++) m_ci[j] = pm1(j + 3);
        load_all();
        run(1'b0);
        check(got_lag == N - 3, "R2 zero fill early lag", got_lag, N - 3);
        check(got_mag == (N - 3) * (N - 3), "R2 zero fill magnitude", got_mag, (N - 3) * (N - 3));
        expect_model("R2 early edge model");
    endtask

    task automatic t_fullscale_tie();
        longint full;
        clear_model();
        for (int n = 0; n < N; n++) begin m_ri[n] = -128; m_rq[n] = -128; end
        for (int j = 0; j < 2*N; j++) begin m_ci[j] = -128; m_cq[j] = -128; end
        load_all();
        run(1'b0);
        full = longint'(N) * 32768;
        check(got_lag == N, "R4 tie keeps earliest lag", got_lag, N);
        check(got_mag == full * full, "R9 full-scale sum exact", got_mag, full * full);
    endtask

    initial begin
        rst_n = 1'b0; ref_we = 1'b0; cap_valid = 1'b0; start = 1'b0;
        ref_addr = '0; ref_i = '0; ref_q = '0; cap_i = '0; cap_q = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_autocorr();
        t_delay_complex();
        t_last_lag();
        t_early_edge();
        t_fullscale_tie();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule